// File: doc/BRIEF.md
# Permuted-Order Three-Bit Counter

This block is a free-running 3-bit state register. It does not count in binary. On every rising clock edge it moves one step along a fixed cycle that visits all eight codes in the order 0, 4, 7, 2, 5, 6, 3, 1 and then returns to 0. Because the cycle covers every code, no state is unused and the counter never needs lock-up recovery.

One active-low input, sampled on the clock edge, clears the counter. When that input is low at a rising edge, the state becomes 0 on that edge, whatever state it was in before. The output is taken straight from the three state flops.

A parameter selects how the next state is produced: either a lookup of the visiting order, or one hand-minimised sum-of-products equation per bit feeding a D flop. Both variants give the same sequence.

Top module: `cnt_perm3`

## Requirements
- R1: The output `q` is a 3-bit unsigned value. It changes only on a rising edge of `clk` and holds its value between edges.
- R2: With `clr_n` high at a rising edge, `q` moves to its successor: 0→4, 4→7, 7→2, 2→5, 5→6, 6→3, 3→1.
- R3: With `clr_n` high, state 1 moves to 0, so the sequence repeats every 8 edges and every code appears exactly once per period.
- R4: With `clr_n` low at a rising edge, `q` becomes 0 on that edge from every one of the eight states, including 0.
- R5: When `clr_n` is held low for several edges, `q` stays at 0. The first edge with `clr_n` high after a clear gives 4.
- R6: The lookup variant (`USE_EQUATIONS`=0) and the per-bit equation variant (`USE_EQUATIONS`=1) give identical output for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low synchronous clear; high lets the counter advance |
| q | output | WIDTH (3) | Current state, unsigned, driven directly by the state flops |

## Verification
On every cycle after the first clear, the assertions check the successor rule and the clear-to-zero rule, and they also check the two ends of the cycle (0→4 and 1→0). Some behaviours show only through the bench's scenarios. These are: output stability between edges, the full 8-edge period seen as one unbroken run, clearing from each of the eight states in turn, and the match between the lookup and equation variants under the same random clear pattern.

// File: rtl/cnt_perm3_pkg.sv
package cnt_perm3_pkg;

   localparam int unsigned CODE_W = 3;

   typedef logic [CODE_W-1:0] code_t;

   // successor of each code in the visiting cycle 0-4-7-2-5-6-3-1
   function automatic code_t succ_of(input code_t cur);
      code_t nxt;
      unique case (cur)
         3'd0:    nxt = 3'd4;
         3'd4:    nxt = 3'd7;
         3'd7:    nxt = 3'd2;
         3'd2:    nxt = 3'd5;
         3'd5:    nxt = 3'd6;
         3'd6:    nxt = 3'd3;
         3'd3:    nxt = 3'd1;
         default: nxt = 3'd0;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/cnt_perm3_next.sv
module cnt_perm3_next
   import cnt_perm3_pkg::*;
#(
   parameter int unsigned WIDTH         = 3,
   parameter bit          USE_EQUATIONS = 1'b0
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             clr_n,
   output logic [WIDTH-1:0] nxt
);
   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] adv;

   generate
      if (USE_EQUATIONS) begin : g_eqn
         // per-bit minimised next-state functions
         logic b2, b1, b0;
         assign b2 = cur[MSB];
         assign b1 = cur[MSB-1];
         assign b0 = cur[0];
         always_comb begin
            adv[2] = (~b0 & ~(b2 & b1)) | (b2 & ~b1);
            adv[1] = b2;
            adv[0] = (~b2 & b1) | (b2 & ~b0);
         end
      end else begin : g_lut
         always_comb adv = succ_of(cur);
      end
   endgenerate

   // clear dominates the sequence
   always_comb nxt = clr_n ? adv : '0;

endmodule

// File: rtl/cnt_perm3_reg.sv
module cnt_perm3_reg #(
   parameter int unsigned WIDTH = 3
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         always_ff @(posedge clk) q[i] <= d[i];
      end
   endgenerate
endmodule

// File: rtl/cnt_perm3.sv
module cnt_perm3 #(
   parameter int unsigned WIDTH         = 3,
   parameter bit          USE_EQUATIONS = 1'b0
) (
   input  logic             clk,
   input  logic             clr_n,
   output logic [WIDTH-1:0] q
);
   localparam int unsigned N_CODES = 1 << WIDTH;

   generate
      if (WIDTH != 3) begin : g_bad_width
         $error("cnt_perm3: WIDTH must be 3");
      end
      if (N_CODES != 8) begin : g_bad_codes
         $error("cnt_perm3: code space must hold eight values");
      end
   endgenerate

   logic [WIDTH-1:0] d_next;

   cnt_perm3_next #(
      .WIDTH        (WIDTH),
      .USE_EQUATIONS(USE_EQUATIONS)
   ) u_next (
      .cur  (q),
      .clr_n(clr_n),
      .nxt  (d_next)
   );

   cnt_perm3_reg #(
      .WIDTH(WIDTH)
   ) u_reg (
      .clk(clk),
      .d  (d_next),
      .q  (q)
   );

endmodule

// File: rtl/cnt_perm3_chk.sv
module cnt_perm3_chk
   import cnt_perm3_pkg::*;
#(
   parameter int unsigned WIDTH = 3
) (
   input logic             clk,
   input logic             clr_n,
   input logic [WIDTH-1:0] q
);
   // armed after the first clear so unknown power-up state is ignored
   logic armed_q = 1'b0;
   always_ff @(posedge clk) if (!clr_n) armed_q <= 1'b1;

   // R4 / R5: clear drives zero on the next edge
   p_clear_zero_r4: assert property (@(posedge clk) disable iff (!armed_q)
      !clr_n |=> (q == '0));

   // R2: advancing follows the visiting order
   p_successor_r2: assert property (@(posedge clk) disable iff (!armed_q)
      clr_n |=> (q == succ_of($past(q))));

   // R3: the cycle closes from 1 back to 0
   p_wrap_r3: assert property (@(posedge clk) disable iff (!armed_q)
      (clr_n && q == 3'd1) |=> (q == 3'd0));

   // R5: leaving zero goes to 4
   p_start_four_r5: assert property (@(posedge clk) disable iff (!armed_q)
      (clr_n && q == 3'd0) |=> (q == 3'd4));

endmodule

bind cnt_perm3 cnt_perm3_chk #(.WIDTH(WIDTH)) u_chk (
   .clk  (clk),
   .clr_n(clr_n),
   .q    (q)
);

// File: tb/cnt_perm3_bench.sv
`timescale 1ns/1ps
module cnt_perm3_bench;

   logic       clk = 1'b0;
   logic       clr_n = 1'b0;
   logic [2:0] q;
   logic [2:0] q_eq;
   logic [2:0] exp_q = 3'd0;
   int         n_checks = 0;
   int         n_errors = 0;
   int         cycles = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   cnt_perm3 #(.WIDTH(3), .USE_EQUATIONS(1'b0)) u_cnt_perm3 (
      .clk(clk), .clr_n(clr_n), .q(q));

   cnt_perm3 #(.WIDTH(3), .USE_EQUATIONS(1'b1)) u_cnt_perm3_eq (
      .clk(clk), .clr_n(clr_n), .q(q_eq));

   // expected successor, from the required order 0,4,7,2,5,6,3,1
   function automatic logic [2:0] ref_next(input logic [2:0] s);
      logic [2:0] order [8];
      order = '{3'd0, 3'd4, 3'd7, 3'd2, 3'd5, 3'd6, 3'd3, 3'd1};
      for (int i = 0; i < 8; i++)
         if (order[i] == s) return order[(i + 1) % 8];
      return 3'd0;
   endfunction

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge; applies c, waits one rising edge, checks
   task automatic step(input logic c, input string req);
      clr_n = c;
      #2.0;
      check("R1", q, exp_q);          // no change before the edge
      @(posedge clk);
      exp_q = c ? ref_next(exp_q) : 3'd0;
      @(negedge clk);
      check(req, q, exp_q);
      check("R6", q_eq, q);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 100000);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      // power-up: clear brings unknown state to zero (R4)
      clr_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      exp_q = 3'd0;
      check("R4", q, 3'd0);
      check("R6", q_eq, 3'd0);
      // held clear stays zero (R5)
      step(1'b0, "R5");
      step(1'b0, "R5");
      // first advance after clear gives 4 (R5)
      step(1'b1, "R5");
      check("R5", q, 3'd4);
      // two-plus full cycles of the order (R2)
      for (int k = 0; k < 18; k++) step(1'b1, "R2");
      // period measured from zero (R3)
      begin
         int len;
         step(1'b0, "R4");
         len = 0;
         do begin
            step(1'b1, "R3");
            len++;
         end while (q != 3'd0 && len < 20);
         n_checks++;
         if (len != 8) begin
            n_errors++;
            $display("FAIL R3: actual=%0d expected=%0d", len, 8);
         end
      end
      // clear from every state (R4)
      for (int s = 0; s < 8; s++) begin
         int guard;
         guard = 0;
         while (exp_q != s[2:0] && guard < 10) begin
            step(1'b1, "R2");
            guard++;
         end
         step(1'b0, "R4");
      end
      // random clear pattern (R2, R4, R6)
      for (int k = 0; k < 400; k++) begin
         logic c;
         c = ($urandom % 5) != 0;
         step(c, c ? "R2" : "R4");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule